// File: doc/BRIEF.md
# Physical Register Rename Unit

This block is the renaming stage in front of a unified physical register file. Every architectural register always names one physical register through a rename table. A decoded instruction looks up its two sources there. If it writes a register, it takes a fresh physical register from a free list and points its destination at that register. The block hands back the physical numbers of both sources, the new destination register and the register the destination named before. No register values pass through the block; it moves numbers only.

Each renamed instruction also takes a slot in an in-flight history, in program order, and the slot index is returned as its tag. When the oldest instruction commits, the register its destination replaced can no longer be read by anyone, so that register goes back to the free list. A separate committed map records the last committed mapping of each architectural register.

A trap request names the tag of the trapping instruction. The block then walks the history backwards, one instruction per cycle, from the youngest down to and including the trapping one. For each instruction that has a destination, it restores the earlier mapping and frees the register the instruction had taken. Renaming is held off until the walk reaches the trapping instruction.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i, stall is low when no trap is asked for, and the free list hands out physical registers ARCH_REGS, ARCH_REGS+1, ... PHYS_REGS-1 in that order.
- R2: ren_psrc1 and ren_psrc2 show, in the same cycle and whether or not dec_valid is set, the current mapping of dec_src1 and dec_src2. These lookups include every update made at earlier clock edges and do not see the update made by the instruction presenting them.
- R3: When an instruction with dec_has_dst=1 is accepted (dec_valid=1 and stall=0), ren_pdst is the register at the front of the free list and ren_lprd is the mapping of dec_dst before this instruction. From the next cycle on, dec_dst maps to ren_pdst.
- R4: An accepted instruction with dec_has_dst=0 takes no register from the free list and changes no mapping, but it still takes a history slot and a tag.
- R5: stall is high while dec_has_dst=1 and the free list is empty. An instruction with dec_has_dst=0 is not stalled by an empty free list.
- R6: stall is high while ROB_DEPTH instructions are in flight.
- R7: ren_tag is the history slot of the instruction being presented. It increases by one, modulo ROB_DEPTH, for each accepted instruction.
- R8: commit_valid retires the oldest in-flight instruction. If that instruction has a destination, its ren_lprd value is appended to the free list. commit_valid has no effect when nothing is in flight or while a recovery walk runs.
- R9: trap_valid, when no recovery is running, raises stall in that cycle and blocks renaming at that edge. The unit then undoes the N instructions from the youngest down to the one tagged trap_tag, one per cycle: each destination gets back its earlier mapping, and the register the instruction took is appended to the free list. stall stays high for N+1 further cycles. When the tag equals the next free slot and the history is not full, N is 0.
- R10: trap_valid is ignored while a recovery walk is running.
- R11: Whenever nothing is in flight and no recovery runs, the rename table equals the committed map.
- R12: A destination register handed out never equals either source mapping presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_valid | input | 1 | A decoded instruction is presented |
| dec_has_dst | input | 1 | The instruction writes a register |
| dec_src1 | input | AW | First source architectural number |
| dec_src2 | input | AW | Second source architectural number |
| dec_dst | input | AW | Destination architectural number |
| commit_valid | input | 1 | Oldest in-flight instruction commits |
| trap_valid | input | 1 | Roll back to the tagged instruction |
| trap_tag | input | IW | Tag of the trapping instruction |
| stall | output | 1 | Instruction cannot be accepted this cycle |
| ren_psrc1 | output | PW | Physical register of dec_src1 |
| ren_psrc2 | output | PW | Physical register of dec_src2 |
| ren_pdst | output | PW | New physical register for the destination |
| ren_lprd | output | PW | Previous physical register of the destination |
| ren_tag | output | IW | History slot of the presented instruction |

## Verification
Lookups, ren_pdst, ren_lprd, ren_tag and stall are combinational in the presentation cycle. The bench drives inputs just after the falling edge and samples these outputs 2 ns later, against a reference model that holds the state as it was before the coming rising edge. Table, free-list and history effects become visible from the next cycle, so the model is advanced right after each rising edge, and the next presentation checks the new state. A trap holds stall high in its own cycle and for N+1 following cycles, and the model counts those cycles down one per edge. Probes with dec_valid low read the whole table back through the source ports after each recovery.

// File: rtl/rn_pkg.sv
package rn_pkg;

    typedef enum logic {
        RN_RUN  = 1'b0,
        RN_UNDO = 1'b1
    } rn_mode_e;

endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 16,
    parameter int NRD       = 3,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NRD-1:0][AW-1:0]        rd_arch,
    output logic [NRD-1:0][PW-1:0]        rd_phys,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_arch,
    input  logic [PW-1:0]                 wr_phys,
    output logic [ARCH_REGS-1:0][PW-1:0]  flat
);

    logic [ARCH_REGS-1:0][PW-1:0] tbl_d, tbl_q;

    // one lookup port per requested read
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_phys[g] = tbl_q[rd_arch[g]];
    end

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d[wr_arch] = wr_phys;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH_REGS; i++) begin
                tbl_q[i] <= PW'(i);
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign flat = tbl_q;

endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 16,
    localparam int PW = $clog2(PHYS_REGS),
    localparam int CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_en,
    input  logic          push_en,
    input  logic [PW-1:0] push_phys,
    output logic [PW-1:0] head_phys,
    output logic          empty,
    output logic [CW-1:0] level
);

    // depth PHYS_REGS (a power of two) so the pointers wrap by themselves
    logic [PHYS_REGS-1:0][PW-1:0] mem_d, mem_q;
    logic [PW-1:0]                rd_d, rd_q, wr_d, wr_q;
    logic [CW-1:0]                cnt_d, cnt_q;

    always_comb begin
        mem_d = mem_q;
        rd_d  = rd_q;
        wr_d  = wr_q;
        cnt_d = cnt_q;
        if (pop_en) begin
            rd_d = rd_q + 1'b1;
        end
        if (push_en) begin
            mem_d[wr_q] = push_phys;
            wr_d        = wr_q + 1'b1;
        end
        case ({push_en, pop_en})
            2'b10:   cnt_d = cnt_q + 1'b1;
            2'b01:   cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS_REGS; i++) begin
                mem_q[i] <= (i < PHYS_REGS - ARCH_REGS) ? PW'(ARCH_REGS + i) : '0;
            end
            rd_q  <= '0;
            wr_q  <= PW'(PHYS_REGS - ARCH_REGS);
            cnt_q <= CW'(PHYS_REGS - ARCH_REGS);
        end else begin
            mem_q <= mem_d;
            rd_q  <= rd_d;
            wr_q  <= wr_d;
            cnt_q <= cnt_d;
        end
    end

    assign head_phys = mem_q[rd_q];
    assign empty     = (cnt_q == '0);
    assign level     = cnt_q;

endmodule

// File: rtl/rn_history.sv
module rn_history #(
    parameter int DEPTH = 16,
    parameter int AW    = 3,
    parameter int PW    = 4,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  logic          push_has,
    input  logic [AW-1:0] push_arch,
    input  logic [PW-1:0] push_prd,
    input  logic [PW-1:0] push_lprd,
    input  logic          pop_head,
    input  logic          pop_tail,
    output logic          head_has,
    output logic [AW-1:0] head_arch,
    output logic [PW-1:0] head_prd,
    output logic [PW-1:0] head_lprd,
    output logic          last_has,
    output logic [AW-1:0] last_arch,
    output logic [PW-1:0] last_prd,
    output logic [PW-1:0] last_lprd,
    output logic [IW-1:0] tail_idx,
    output logic [CW-1:0] count,
    output logic          full
);

    typedef struct packed {
        logic          has;
        logic [AW-1:0] arch;
        logic [PW-1:0] prd;
        logic [PW-1:0] lprd;
    } slot_t;

    slot_t [DEPTH-1:0] mem_d, mem_q;
    logic  [IW-1:0]    hd_d, hd_q, tl_d, tl_q;
    logic  [CW-1:0]    cnt_d, cnt_q;
    logic  [IW-1:0]    last_idx;
    slot_t             head_s, last_s;

    assign last_idx = tl_q - 1'b1;
    assign head_s   = mem_q[hd_q];
    assign last_s   = mem_q[last_idx];

    always_comb begin
        mem_d = mem_q;
        hd_d  = hd_q;
        tl_d  = tl_q;
        cnt_d = cnt_q;
        // the owner never pushes and pops the tail in the same cycle
        if (push_en) begin
            mem_d[tl_q] = '{has: push_has, arch: push_arch, prd: push_prd, lprd: push_lprd};
            tl_d        = tl_q + 1'b1;
            cnt_d       = cnt_d + 1'b1;
        end
        if (pop_tail) begin
            tl_d  = tl_q - 1'b1;
            cnt_d = cnt_d - 1'b1;
        end
        if (pop_head) begin
            hd_d  = hd_q + 1'b1;
            cnt_d = cnt_d - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
            hd_q  <= '0;
            tl_q  <= '0;
            cnt_q <= '0;
        end else begin
            mem_q <= mem_d;
            hd_q  <= hd_d;
            tl_q  <= tl_d;
            cnt_q <= cnt_d;
        end
    end

    assign head_has  = head_s.has;
    assign head_arch = head_s.arch;
    assign head_prd  = head_s.prd;
    assign head_lprd = head_s.lprd;
    assign last_has  = last_s.has;
    assign last_arch = last_s.arch;
    assign last_prd  = last_s.prd;
    assign last_lprd = last_s.lprd;
    assign tail_idx  = tl_q;
    assign count     = cnt_q;
    assign full      = (cnt_q == CW'(DEPTH));

endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit #(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 16,
    parameter int ROB_DEPTH = 16,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS),
    localparam int IW = $clog2(ROB_DEPTH),
    localparam int CW = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic          dec_has_dst,
    input  logic [AW-1:0] dec_src1,
    input  logic [AW-1:0] dec_src2,
    input  logic [AW-1:0] dec_dst,
    input  logic          commit_valid,
    input  logic          trap_valid,
    input  logic [IW-1:0] trap_tag,
    output logic          stall,
    output logic [PW-1:0] ren_psrc1,
    output logic [PW-1:0] ren_psrc2,
    output logic [PW-1:0] ren_pdst,
    output logic [PW-1:0] ren_lprd,
    output logic [IW-1:0] ren_tag
);
    import rn_pkg::*;

    typedef struct packed {
        rn_mode_e                     mode;
        logic [CW-1:0]                left;
        logic [ARCH_REGS-1:0][PW-1:0] cmt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // free list
    logic          fl_pop, fl_push, fl_empty;
    logic [PW-1:0] fl_push_phys, fl_head;
    logic [PW:0]   fl_level;

    // history
    logic          h_push, h_pop_head, h_pop_tail, h_full;
    logic          h_head_has, h_last_has;
    logic [AW-1:0] h_head_arch, h_last_arch;
    logic [PW-1:0] h_head_prd, h_head_lprd, h_last_prd, h_last_lprd;
    logic [IW-1:0] h_tail;
    logic [CW-1:0] h_count;

    // rename table
    logic [2:0][AW-1:0]           rt_rd_arch;
    logic [2:0][PW-1:0]           rt_rd_phys;
    logic                         rt_wr_en;
    logic [AW-1:0]                rt_wr_arch;
    logic [PW-1:0]                rt_wr_phys;
    logic [ARCH_REGS-1:0][PW-1:0] map_flat;
    logic [ARCH_REGS-1:0][PW-1:0] cmt_flat;

    // control strobes
    logic          busy, ren_fire, ren_take, cmt_fire, undo_fire, trap_acc;
    logic [IW-1:0] trap_dist;

    assign rt_rd_arch = {dec_dst, dec_src2, dec_src1};

    rn_map_table #(
        .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .NRD(3)
    ) u_map (
        .clk(clk), .rst_n(rst_n),
        .rd_arch(rt_rd_arch), .rd_phys(rt_rd_phys),
        .wr_en(rt_wr_en), .wr_arch(rt_wr_arch), .wr_phys(rt_wr_phys),
        .flat(map_flat)
    );

    rn_free_list #(
        .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)
    ) u_free (
        .clk(clk), .rst_n(rst_n),
        .pop_en(fl_pop), .push_en(fl_push), .push_phys(fl_push_phys),
        .head_phys(fl_head), .empty(fl_empty), .level(fl_level)
    );

    rn_history #(
        .DEPTH(ROB_DEPTH), .AW(AW), .PW(PW)
    ) u_hist (
        .clk(clk), .rst_n(rst_n),
        .push_en(h_push), .push_has(dec_has_dst), .push_arch(dec_dst),
        .push_prd(fl_head), .push_lprd(rt_rd_phys[2]),
        .pop_head(h_pop_head), .pop_tail(h_pop_tail),
        .head_has(h_head_has), .head_arch(h_head_arch),
        .head_prd(h_head_prd), .head_lprd(h_head_lprd),
        .last_has(h_last_has), .last_arch(h_last_arch),
        .last_prd(h_last_prd), .last_lprd(h_last_lprd),
        .tail_idx(h_tail), .count(h_count), .full(h_full)
    );

    always_comb begin
        ctl_d     = ctl_q;
        busy      = (ctl_q.mode == RN_UNDO);
        stall     = busy || trap_valid || h_full || (dec_has_dst && fl_empty);
        ren_fire  = dec_valid && !stall;
        ren_take  = ren_fire && dec_has_dst;
        cmt_fire  = commit_valid && !busy && (h_count != '0);
        undo_fire = busy && (ctl_q.left != '0);
        trap_acc  = trap_valid && !busy;
        trap_dist = h_tail - trap_tag;

        h_push     = ren_fire;
        h_pop_head = cmt_fire;
        h_pop_tail = undo_fire;
        fl_pop     = ren_take;

        // undo and rename never overlap: rename is stalled while busy
        rt_wr_en   = 1'b0;
        rt_wr_arch = dec_dst;
        rt_wr_phys = fl_head;
        if (undo_fire && h_last_has) begin
            rt_wr_en   = 1'b1;
            rt_wr_arch = h_last_arch;
            rt_wr_phys = h_last_lprd;
        end else if (ren_take) begin
            rt_wr_en = 1'b1;
        end

        // commit and undo never overlap: commit is ignored while busy
        fl_push      = 1'b0;
        fl_push_phys = h_head_lprd;
        if (undo_fire && h_last_has) begin
            fl_push      = 1'b1;
            fl_push_phys = h_last_prd;
        end else if (cmt_fire && h_head_has) begin
            fl_push = 1'b1;
        end

        if (cmt_fire && h_head_has) begin
            ctl_d.cmt[h_head_arch] = h_head_prd;
        end

        if (undo_fire) begin
            ctl_d.left = ctl_q.left - 1'b1;
        end else if (busy) begin
            ctl_d.mode = RN_RUN;
        end

        if (trap_acc) begin
            ctl_d.mode = RN_UNDO;
            if (trap_dist == '0 && h_full) begin
                ctl_d.left = CW'(ROB_DEPTH);
            end else begin
                ctl_d.left = CW'(trap_dist);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.mode <= RN_RUN;
            ctl_q.left <= '0;
            for (int i = 0; i < ARCH_REGS; i++) begin
                ctl_q.cmt[i] <= PW'(i);
            end
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ren_psrc1 = rt_rd_phys[0];
    assign ren_psrc2 = rt_rd_phys[1];
    assign ren_lprd  = rt_rd_phys[2];
    assign ren_pdst  = fl_head;
    assign ren_tag   = h_tail;
    assign cmt_flat  = ctl_q.cmt;

endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 16,
    parameter int ROB_DEPTH = 16,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS),
    localparam int IW = $clog2(ROB_DEPTH),
    localparam int CW = IW + 1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         dec_valid,
    input logic                         dec_has_dst,
    input logic [AW-1:0]                dec_src1,
    input logic [AW-1:0]                dec_dst,
    input logic                         trap_valid,
    input logic                         stall,
    input logic [PW-1:0]                ren_psrc1,
    input logic [PW-1:0]                ren_psrc2,
    input logic [PW-1:0]                ren_pdst,
    input logic [PW-1:0]                ren_lprd,
    input logic [IW-1:0]                ren_tag,
    input logic                         busy,
    input logic                         fl_empty,
    input logic                         h_full,
    input logic [CW-1:0]                h_count,
    input logic [ARCH_REGS-1:0][PW-1:0] map_flat,
    input logic [ARCH_REGS-1:0][PW-1:0] cmt_flat
);

    assert_lprd_lookup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_src1 == dec_dst) |-> (ren_psrc1 == ren_lprd));

    assert_stall_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_has_dst && fl_empty) |-> stall);

    assert_stall_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        h_full |-> stall);

    assert_tag_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !stall) |=> (ren_tag == IW'($past(ren_tag) + 1'b1)));

    assert_trap_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !busy) |=> (busy && stall));

    assert_tables_agree_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && h_count == '0) |-> (map_flat == cmt_flat));

    assert_fresh_dst_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !stall && dec_has_dst) |->
            (ren_pdst != ren_psrc1 && ren_pdst != ren_psrc2));

endmodule

bind rn_rename_unit rn_rename_chk #(
    .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .ROB_DEPTH(ROB_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dec_valid), .dec_has_dst(dec_has_dst),
    .dec_src1(dec_src1), .dec_dst(dec_dst),
    .trap_valid(trap_valid), .stall(stall),
    .ren_psrc1(ren_psrc1), .ren_psrc2(ren_psrc2),
    .ren_pdst(ren_pdst), .ren_lprd(ren_lprd), .ren_tag(ren_tag),
    .busy(busy), .fl_empty(fl_empty), .h_full(h_full), .h_count(h_count),
    .map_flat(map_flat), .cmt_flat(cmt_flat)
);

// File: tb/sim_rn_rename_unit.sv
module sim_rn_rename_unit;

    localparam int A  = 8;
    localparam int P  = 16;
    localparam int D  = 16;
    localparam int AW = $clog2(A);
    localparam int PW = $clog2(P);
    localparam int IW = $clog2(D);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dec_valid = 1'b0, dec_has_dst = 1'b0;
    logic [AW-1:0] dec_src1 = '0, dec_src2 = '0, dec_dst = '0;
    logic          commit_valid = 1'b0, trap_valid = 1'b0;
    logic [IW-1:0] trap_tag = '0;
    logic          stall;
    logic [PW-1:0] ren_psrc1, ren_psrc2, ren_pdst, ren_lprd;
    logic [IW-1:0] ren_tag;

    rn_rename_unit #(.ARCH_REGS(A), .PHYS_REGS(P), .ROB_DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_has_dst(dec_has_dst),
        .dec_src1(dec_src1), .dec_src2(dec_src2), .dec_dst(dec_dst),
        .commit_valid(commit_valid), .trap_valid(trap_valid), .trap_tag(trap_tag),
        .stall(stall), .ren_psrc1(ren_psrc1), .ren_psrc2(ren_psrc2),
        .ren_pdst(ren_pdst), .ren_lprd(ren_lprd), .ren_tag(ren_tag)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        bit has;
        int arch;
        int prd;
        int lprd;
        int tag;
    } ent_t;

    int   m_map [A];
    int   m_free[$];
    ent_t m_hist[$];
    bit   m_undo;
    int   m_left;
    int   m_tail;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    function automatic bit exp_stall(input bit hd, input bit tv);
        return m_undo || tv || (m_hist.size() == D) || (hd && m_free.size() == 0);
    endfunction

    function automatic string stall_req(input bit hd, input bit tv);
        if (m_undo || tv)               return "R9";
        if (m_hist.size() == D)          return "R6";
        if (hd && m_free.size() == 0)    return "R5";
        return "R4";
    endfunction

    task automatic model_reset();
        for (int i = 0; i < A; i++) m_map[i] = i;
        m_free.delete();
        for (int i = A; i < P; i++) m_free.push_back(i);
        m_hist.delete();
        m_undo = 1'b0;
        m_left = 0;
        m_tail = 0;
    endtask

    // one cycle: drive, check the combinational outputs, clock, advance the model
    task automatic step(input bit v, input bit hd, input int s1, input int s2,
                        input int d, input bit cv, input bit tv, input int tt);
        bit st, fire, cfire, tacc;
        @(negedge clk);
        dec_valid    = v;
        dec_has_dst  = hd;
        dec_src1     = AW'(s1);
        dec_src2     = AW'(s2);
        dec_dst      = AW'(d);
        commit_valid = cv;
        trap_valid   = tv;
        trap_tag     = IW'(tt);
        #2;
        st = exp_stall(hd, tv);
        check(stall == st, stall_req(hd, tv), "stall", int'(stall), int'(st));
        check(int'(ren_psrc1) == m_map[s1], "R2", "psrc1", int'(ren_psrc1), m_map[s1]);
        check(int'(ren_psrc2) == m_map[s2], "R2", "psrc2", int'(ren_psrc2), m_map[s2]);
        fire = v && !st;
        if (fire) begin
            check(int'(ren_tag) == m_tail, "R7", "tag", int'(ren_tag), m_tail);
            if (hd) begin
                check(int'(ren_pdst) == m_free[0], "R3", "pdst", int'(ren_pdst), m_free[0]);
                check(int'(ren_lprd) == m_map[d], "R3", "lprd", int'(ren_lprd), m_map[d]);
            end
        end
        cfire = cv && !m_undo && (m_hist.size() != 0);
        tacc  = tv && !m_undo;
        @(posedge clk);
        if (m_undo) begin
            if (m_left != 0) begin
                ent_t e;
                e = m_hist.pop_back();
                if (e.has) begin
                    m_map[e.arch] = e.lprd;
                    m_free.push_back(e.prd);
                end
                m_tail = (m_tail + D - 1) % D;
                m_left--;
            end else begin
                m_undo = 1'b0;
            end
        end
        if (cfire) begin
            ent_t e;
            e = m_hist.pop_front();
            if (e.has) m_free.push_back(e.lprd);
        end
        if (fire) begin
            ent_t e;
            e.has  = hd;
            e.arch = d;
            e.tag  = m_tail;
            e.prd  = 0;
            e.lprd = 0;
            if (hd) begin
                e.prd  = m_free.pop_front();
                e.lprd = m_map[d];
                m_map[d] = e.prd;
            end
            m_hist.push_back(e);
            m_tail = (m_tail + 1) % D;
        end
        if (tacc) begin
            int idx;
            idx = m_hist.size();
            for (int i = 0; i < m_hist.size(); i++) begin
                if (m_hist[i].tag == tt && idx == m_hist.size()) idx = i;
            end
            m_undo = 1'b1;
            m_left = m_hist.size() - idx;
        end
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wait_recovery();
        while (m_undo) step(1, 1, 0, 1, 2, 1, 0, 0);
    endtask

    // read the whole table back through the source ports
    task automatic probe_all(input string req);
        for (int i = 0; i < A; i++) begin
            @(negedge clk);
            dec_valid = 1'b0; dec_has_dst = 1'b0; commit_valid = 1'b0; trap_valid = 1'b0;
            dec_src1 = AW'(i);
            dec_src2 = AW'((i + 1) % A);
            #2;
            check(int'(ren_psrc1) == m_map[i], req, "table probe", int'(ren_psrc1), m_map[i]);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: identity mapping, stall low, first free register
        for (int i = 0; i < A; i++) begin
            @(negedge clk);
            dec_src1 = AW'(i);
            #2;
            check(int'(ren_psrc1) == i, "R1", "reset map", int'(ren_psrc1), i);
        end
        check(stall == 1'b0, "R1", "reset stall", int'(stall), 0);
        dec_has_dst = 1'b1;
        #1;
        check(int'(ren_pdst) == A, "R1", "first free", int'(ren_pdst), A);

        // R3/R2: rename reading its own destination sees the old mapping
        step(1, 1, 3, 3, 3, 0, 0, 0);
        step(1, 1, 3, 0, 3, 0, 0, 0);
        // exhaust the free list (R5)
        for (int i = 0; i < P - A - 2; i++) step(1, 1, i % A, (i + 2) % A, (i * 3) % A, 0, 0, 0);
        step(1, 1, 1, 2, 4, 0, 0, 0);              // stalled: list empty (R5)
        step(1, 0, 5, 6, 0, 0, 0, 0);              // no destination proceeds (R4, R5)
        step(1, 1, 1, 2, 4, 1, 0, 0);              // stalled while a commit frees a register (R8)
        step(1, 1, 1, 2, 4, 0, 0, 0);              // now accepted, takes the freed register

        // R9: roll back to the third in-flight instruction, commits ignored (R8), trap ignored (R10)
        step(0, 0, 0, 0, 0, 0, 1, m_hist[2].tag);
        step(1, 1, 0, 1, 2, 1, 1, m_hist[0].tag);
        wait_recovery();
        probe_all("R9");

        // drain, then commit with nothing in flight (R8)
        while (m_hist.size() != 0) step(0, 0, 0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0, 0);
        step(1, 1, 2, 3, 2, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0, 0);
        probe_all("R11");

        // R6: fill the history with no-destination instructions, then undo everything
        while (m_hist.size() < D) step(1, 0, 1, 2, 3, 0, 0, 0);
        step(1, 0, 1, 2, 3, 0, 0, 0);
        step(1, 1, 1, 2, 3, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, m_tail);          // tag equals head: whole history undone
        wait_recovery();
        check(m_hist.size() == 0, "R9", "history emptied", m_hist.size(), 0);
        step(1, 1, 0, 1, 6, 0, 0, 0);
        // trap naming the next free slot: nothing to undo
        step(0, 0, 0, 0, 0, 0, 1, m_tail);
        wait_recovery();
        probe_all("R9");

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            bit v, hd, cv, tv;
            int tt, pick;
            v  = ($urandom_range(0, 3) != 0);
            hd = ($urandom_range(0, 3) != 0);
            cv = ($urandom_range(0, 9) < 4);
            tv = ($urandom_range(0, 49) == 0);
            tt = m_tail;
            if (tv) begin
                cv = 1'b0;
                pick = $urandom_range(0, m_hist.size());
                if (pick < m_hist.size()) tt = m_hist[pick].tag;
            end
            step(v, hd, $urandom_range(0, A - 1), $urandom_range(0, A - 1),
                 $urandom_range(0, A - 1), cv, tv, tt);
        end
        wait_recovery();
        probe_all("R2");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule